// File: doc/BRIEF.md
# Write Combining Burst Chainer

This block sits between a processor write port and a burst-capable downstream master. The processor sends 64-bit quadword writes. When each write lands exactly one quadword above the one before it, the block gathers them and sends them on as one burst of up to four beats. The burst is tagged with the address of its first quadword and its beat count.

A group is sent on when it fills to four quadwords, when a write arrives that does not continue it, or when the processor leaves it alone for a programmable number of idle cycles. A run-time enable turns gathering off. With it off, every accepted write leaves at once as a single-beat burst. The processor port is held off while a burst is being sent, and also while a write that breaks the current run waits for the pending group to go out first.

Top module: `wc_burst_chainer`

## Requirements
- R1: After reset, `bus_valid` is 0 and `cpu_ready` is 1 while no write is offered.
- R2: With `comb_en` high, a write to the previous write's address plus 8 joins the pending group. The burst carries the group's first address on `bus_addr` and the beat count (1 to 4) on `bus_len`, and its data beats come out in write order.
- R3: A group that reaches four quadwords is issued at once, without waiting for the idle timeout. A fifth contiguous write starts a new group.
- R4: A write that does not continue the pending group, whether backward, repeated or skipping ahead, is held off until the pending group has been issued, and then starts a new group.
- R5: A partial group with no write offered is issued after `IDLE_LIMIT` idle cycles. Its first beat is visible in the (`IDLE_LIMIT`+2)-th cycle after the cycle in which its last write was accepted.
- R6: With `comb_en` low, each accepted write is issued as its own burst with `bus_len` = 1. A group still pending when `comb_en` falls is issued before the next write is accepted.
- R7: While `bus_valid` is high and `bus_ready` is low, `bus_valid`, `bus_addr`, `bus_len` and `bus_data` hold.
- R8: `bus_last` is high on the final beat of a burst only, and `bus_valid` falls in the cycle after that beat is taken.
- R9: `cpu_ready` is low in every cycle in which `bus_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| comb_en | input | 1 | 1 = gather contiguous writes, 0 = single-beat writes |
| cpu_valid | input | 1 | Processor write offered |
| cpu_ready | output | 1 | Processor write accepted this cycle when valid |
| cpu_addr | input | AW (32) | Quadword-aligned byte address of the write |
| cpu_data | input | DW (64) | Write data |
| bus_valid | output | 1 | Burst beat offered downstream |
| bus_ready | input | 1 | Downstream takes the beat |
| bus_addr | output | AW (32) | Start address of the burst |
| bus_len | output | 3 | Beat count of the burst, 1 to 4 |
| bus_data | output | DW (64) | Data of the current beat |
| bus_last | output | 1 | Current beat is the final one |

## Verification
The assertions assume that processor addresses are quadword aligned and that the burst start address plus three quadwords does not wrap. They also assume that `comb_en` changes only while no write is offered. The stimulus meets these assumptions: it uses aligned addresses well below the top of the address space. It keeps each request asserted until the handshake completes and then drops it. It moves `comb_en` only between requests. `bus_ready` may follow any pattern, and the stimulus switches between stalling patterns and always-ready to exercise the hold rule.

// File: rtl/wc_burst_chainer.sv
module wc_burst_chainer #(
  parameter int AW         = 32,
  parameter int DW         = 64,
  parameter int MAX_BEATS  = 4,
  parameter int IDLE_LIMIT = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              comb_en,
  input  logic                              cpu_valid,
  output logic                              cpu_ready,
  input  logic [AW-1:0]                     cpu_addr,
  input  logic [DW-1:0]                     cpu_data,
  output logic                              bus_valid,
  input  logic                              bus_ready,
  output logic [AW-1:0]                     bus_addr,
  output logic [$clog2(MAX_BEATS+1)-1:0]    bus_len,
  output logic [DW-1:0]                     bus_data,
  output logic                              bus_last
);
  localparam int CW    = $clog2(MAX_BEATS+1);
  localparam int BW    = $clog2(MAX_BEATS);
  localparam int IW    = $clog2(IDLE_LIMIT+1);
  localparam int SHIFT = $clog2(DW/8);

  logic [DW-1:0] qbuf [MAX_BEATS];
  logic [AW-1:0] base;
  logic [CW-1:0] cnt;
  logic [BW-1:0] beat;
  logic [IW-1:0] idle;
  logic          issuing;

  wire [AW-1:0] next_addr = base + (AW'(cnt) << SHIFT);
  wire pending  = cnt != '0;
  wire contig   = comb_en && pending && cpu_addr == next_addr;
  wire blocked  = pending && cpu_valid && !contig;
  wire take     = cpu_valid && cpu_ready;
  wire timeout  = pending && idle == IW'(IDLE_LIMIT);
  wire close_on_take = !comb_en || cnt == CW'(MAX_BEATS-1);
  wire final_beat    = CW'(beat) == cnt - CW'(1);

  assign cpu_ready = !issuing && !blocked;
  assign bus_valid = issuing;
  assign bus_addr  = base;
  assign bus_len   = cnt;
  assign bus_data  = qbuf[beat];
  assign bus_last  = issuing && final_beat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      issuing <= 1'b0;
      cnt     <= '0;
      beat    <= '0;
      idle    <= '0;
      base    <= '0;
    end else if (issuing) begin
      if (bus_ready) begin
        if (final_beat) begin
          issuing <= 1'b0;
          cnt     <= '0;
          beat    <= '0;
          idle    <= '0;
        end else begin
          beat <= beat + BW'(1);
        end
      end
    end else if (take) begin
      if (!pending) base <= cpu_addr;
      cnt  <= cnt + CW'(1);
      idle <= '0;
      if (close_on_take) issuing <= 1'b1;
    end else if (blocked || timeout) begin
      issuing <= 1'b1;
    end else if (pending) begin
      idle <= idle + IW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (take) qbuf[BW'(cnt)] <= cpu_data;
  end
endmodule

// File: rtl/wc_burst_chainer_chk.sv
module wc_burst_chainer_chk #(
  parameter int AW        = 32,
  parameter int DW        = 64,
  parameter int CW        = 3,
  parameter int MAX_BEATS = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          comb_en,
  input logic          cpu_valid,
  input logic          cpu_ready,
  input logic          bus_valid,
  input logic          bus_ready,
  input logic [AW-1:0] bus_addr,
  input logic [CW-1:0] bus_len,
  input logic [DW-1:0] bus_data,
  input logic          bus_last
);
  p_len_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> (bus_len >= CW'(1) && bus_len <= CW'(MAX_BEATS)));

  p_single_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_ready && !comb_en) |=> (bus_valid && bus_len == CW'(1)));

  p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_len) && $stable(bus_data)));

  p_drop_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ready && bus_last) |=> !bus_valid);

  p_stall_while_issue_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> !cpu_ready);
endmodule

bind wc_burst_chainer wc_burst_chainer_chk #(
  .AW(AW), .DW(DW), .CW(CW), .MAX_BEATS(MAX_BEATS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .comb_en(comb_en), .cpu_valid(cpu_valid),
  .cpu_ready(cpu_ready), .bus_valid(bus_valid), .bus_ready(bus_ready),
  .bus_addr(bus_addr), .bus_len(bus_len), .bus_data(bus_data), .bus_last(bus_last)
);

// File: tb/wc_burst_chainer_tb.sv
module wc_burst_chainer_tb;
  localparam int AW = 32, DW = 64, MB = 4, IL = 6, CW = 3;

  logic clk = 1'b0, rst_n = 1'b0, comb_en = 1'b1, cpu_valid = 1'b0, bus_ready = 1'b1;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_data = '0;
  logic cpu_ready, bus_valid, bus_last;
  logic [AW-1:0] bus_addr;
  logic [CW-1:0] bus_len;
  logic [DW-1:0] bus_data;

  always #2.5 clk = ~clk;

  wc_burst_chainer #(.AW(AW), .DW(DW), .MAX_BEATS(MB), .IDLE_LIMIT(IL)) u_dut (
    .clk(clk), .rst_n(rst_n), .comb_en(comb_en), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
    .cpu_addr(cpu_addr), .cpu_data(cpu_data), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_addr(bus_addr), .bus_len(bus_len), .bus_data(bus_data), .bus_last(bus_last));

  int checks = 0, errors = 0, cyc = 0, ready_mode = 0;
  bit done = 1'b0;

  logic [AW-1:0] e_addr [256];
  int            e_len  [256];
  logic [DW-1:0] e_data [256];
  bit            e_last [256];
  string         e_tag  [256];
  int e_n = 0;
  logic [AW-1:0] a_addr [256];
  int            a_len  [256];
  logic [DW-1:0] a_data [256];
  bit            a_last [256];
  int a_n = 0;

  logic [AW-1:0] m_base = '0;
  int            m_cnt  = 0;
  logic [DW-1:0] m_q [4];
  string         tag = "R2";

  function automatic logic [DW-1:0] dat(input logic [AW-1:0] a);
    return {a ^ 32'hA5A5_0000, ~a};
  endfunction

  task automatic check(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic void mflush();
    for (int i = 0; i < m_cnt; i++) begin
      e_addr[e_n] = m_base; e_len[e_n] = m_cnt; e_data[e_n] = m_q[i];
      e_last[e_n] = (i == m_cnt - 1); e_tag[e_n] = tag; e_n++;
    end
    m_cnt = 0;
  endfunction

  task automatic wr(input logic [AW-1:0] a);
    if (m_cnt > 0 && !(comb_en && a == m_base + AW'(8 * m_cnt))) mflush();
    if (m_cnt == 0) m_base = a;
    m_q[m_cnt] = dat(a); m_cnt++;
    if (!comb_en || m_cnt == MB) mflush();
    @(negedge clk);
    cpu_valid = 1'b1; cpu_addr = a; cpu_data = dat(a);
    forever begin
      #0.5;
      if (cpu_ready) break;
      @(negedge clk);
    end
    @(posedge clk);
    #0.5 cpu_valid = 1'b0;
  endtask

  task automatic settle();
    mflush();
    repeat (IL + 40) @(posedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    #1;
    case (ready_mode)
      0: bus_ready = 1'b1;
      1: bus_ready = (cyc % 3) != 0;
      default: bus_ready = (cyc % 5) >= 3;
    endcase
  end

  logic          p_hold = 1'b0;
  logic [AW-1:0] p_addr;
  logic [CW-1:0] p_len;
  logic [DW-1:0] p_data;
  always @(negedge clk) if (rst_n) begin
    if (bus_valid) check(!cpu_ready, "R9", "cpu_ready while issuing", longint'(cpu_ready), 0);
    if (p_hold)
      check(bus_valid && bus_addr == p_addr && bus_len == p_len && bus_data == p_data,
            "R7", "beat changed while stalled", longint'(bus_data), longint'(p_data));
    p_hold = bus_valid && !bus_ready;
    p_addr = bus_addr; p_len = bus_len; p_data = bus_data;
    if (bus_valid && bus_ready && a_n < 256) begin
      a_addr[a_n] = bus_addr; a_len[a_n] = int'(bus_len);
      a_data[a_n] = bus_data; a_last[a_n] = bus_last; a_n++;
    end
  end

  always @(posedge clk) if (cyc > 100000 && !done) begin
    done = 1'b1;
    errors++; checks++;
    $display("FAIL watchdog: actual %0d cycles expected below 100000", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!bus_valid, "R1", "bus_valid after reset", longint'(bus_valid), 0);
    check(cpu_ready, "R1", "cpu_ready after reset", longint'(cpu_ready), 1);

    for (int rm = 0; rm < 3; rm++) begin
      ready_mode = rm;
      comb_en = 1'b1;
      for (int n = 1; n <= 9; n++) begin
        tag = (n >= MB) ? "R3" : "R2";
        for (int k = 0; k < n; k++) wr(32'h1000 * (rm + 1) + 32'h100 * n + 32'(8 * k));
        settle();
      end
      tag = "R4";
      wr(32'h8000); wr(32'h8008); wr(32'h8040); wr(32'h8048);
      wr(32'h8040); wr(32'h8040); wr(32'h8010); wr(32'h8018);
      settle();
      tag = "R6";
      wr(32'h9000); wr(32'h9008);
      @(negedge clk) comb_en = 1'b0;
      wr(32'h9010); wr(32'h9018); wr(32'h9020);
      settle();
      comb_en = 1'b1;
    end

    ready_mode = 0;
    tag = "R5";
    for (int n = 1; n <= 3; n++) begin
      int k;
      for (int j = 0; j < n; j++) wr(32'hA000 + 32'h100 * n + 32'(8 * j));
      k = 0;
      do begin
        @(negedge clk); k++;
      end while (!bus_valid && k < 50);
      check(k == IL + 2, "R5", "idle flush delay", k, IL + 2);
      check(int'(bus_len) == n, "R5", "idle flush length", longint'(bus_len), n);
      settle();
    end

    check(a_n == e_n, "R2", "beat count", a_n, e_n);
    for (int i = 0; i < e_n && i < a_n; i++) begin
      check(a_addr[i] == e_addr[i], e_tag[i], "burst address", longint'(a_addr[i]), longint'(e_addr[i]));
      check(a_len[i] == e_len[i], e_tag[i], "burst length", a_len[i], e_len[i]);
      check(a_data[i] == e_data[i], e_tag[i], "beat data", longint'(a_data[i]), longint'(e_data[i]));
      check(a_last[i] == e_last[i], "R8", "last flag", longint'(a_last[i]), longint'(e_last[i]));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule